// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge function. A configuration agent outside the block reads a 32-bit word at any time and writes with per-byte enables. Every byte has a fixed write behaviour:

- plain writable;
- write-one-to-clear, for status bits;
- read-only, holding its reset value.

Reset loads the identity header and the vendor-defined defaults for the processor and memory configuration words.

The bank start and end bytes, the extended start and end bytes, the bank enable byte, the processor configuration words and the first memory configuration word are exported as flat vectors to the address decoder. The decoder must recompute its map after a write to the memory-map window. For that, the block raises `mapUpdate` for one cycle after any such write.

Error logic outside the block sets status bits through `errSet`. A start-up auto-configuration path sets the memory-enable bit through `autoMemGo`.

Top module: `hostcfg_space`

## Requirements
- R1: After reset the header reads word 0x00 = 0x00011057 (vendor 0x1057, device 0x0001), word 0x04 = 0x00800006 (bus master and memory enable in command, fast back-to-back in status) and word 0x08 = 0x06000000 (host bridge class).
- R2: After reset word 0xA8 = 0xFF000010, word 0xAC = 0x000C060C, word 0xB8 = 0x00040000, word 0xC0 = 0x00000001, word 0xF0 = 0xFF020000, word 0xF4 = 0x00000003 and word 0xFC = 0x00100000. All other bytes from 0x40 upward read zero.
- R3: Bytes 0x70-0x71, 0x80-0xA0, 0xA8-0xAF, 0xBA-0xBB, 0xC0 and 0xC4 take the written data. This happens only in lanes whose `cfgBe` bit is set; lane k carries byte address 4*word+k in data bits [8k+7:8k].
- R4: Writes leave every other byte unchanged, including the header, 0xA1-0xA7 and the whole 0xF0-0xFF range.
- R5: In bytes 0xC1, 0xC3, 0xC5 and 0xC7, a written 1 clears that bit and a written 0 leaves it unchanged.
- R6: `errSet` bits [7:0], [15:8], [23:16] and [31:24] set bits of bytes 0xC1, 0xC3, 0xC5 and 0xC7. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: `mapUpdate` is high for exactly the cycle after a write with at least one byte enable to a word from 0x80 to 0xA0 inclusive, or to word 0xF0. It stays low otherwise.
- R8: A cycle with `autoMemGo` high sets bit 19 of word 0xF0 from the next cycle on, without raising `mapUpdate`.
- R9: The exported vectors follow the stored bytes in the cycle after a write. `bankStart` carries bytes 0x80-0x87, `bankStartExt` 0x88-0x8F, `bankEnd` 0x90-0x97, `bankEndExt` 0x98-0x9F, `bankEn` 0xA0, `procCfg` 0xA8-0xAF and `memCfg1` 0xF0-0xF3; the lowest address sits in the lowest bits.
- R10: A single write to a word that mixes byte kinds applies each byte's own rule independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Write strobe, one cycle per write |
| cfgAddr | input | 6 | Word index (byte address bits 7:2) for read and write |
| cfgBe | input | 4 | Byte-lane enables of a write |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Word at `cfgAddr`, combinational from the stored bytes |
| errSet | input | 32 | Status-bit set requests for the four clear-on-write bytes |
| autoMemGo | input | 1 | Sets the memory-enable bit 19 of word 0xF0 |
| bankStart | output | 64 | Bank start bytes |
| bankStartExt | output | 64 | Bank extended start bytes |
| bankEnd | output | 64 | Bank end bytes |
| bankEndExt | output | 64 | Bank extended end bytes |
| bankEn | output | 8 | Bank enable byte |
| procCfg | output | 64 | Processor configuration words |
| memCfg1 | output | 32 | First memory configuration word |
| mapUpdate | output | 1 | One-cycle strobe after a memory-map write |

## Verification
The assertions assume the inputs carry known values once reset is released. They also assume that `cfgBe` matters only while `cfgWr` is high. Under those assumptions, word 0xF0 can change only through `autoMemGo`, and the bank enable byte only through a lane-0 write to word 0xA0.

The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It returns `cfgBe` and `errSet` to zero between operations, so no stray set or write overlaps a check, except for the one set-versus-clear case that is staged on purpose.

// File: rtl/hostcfg_pkg.sv
package hostcfg_pkg;

  localparam int unsigned CFG_BYTES  = 256;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BE_W       = DATA_W / 8;
  localparam int unsigned WORD_AW    = $clog2(CFG_BYTES / BE_W);
  localparam int unsigned NUM_BANKS  = 8;
  localparam int unsigned ERR_BYTES  = 4;
  localparam int unsigned SPACE_W    = CFG_BYTES * 8;

  // memory-map window, in word units
  localparam int unsigned MAP_LO_WORD  = 'h80 / BE_W;
  localparam int unsigned MAP_HI_WORD  = 'hA0 / BE_W;
  localparam int unsigned MEMCFG_WORD  = 'hF0 / BE_W;
  localparam int unsigned MEMGO_BYTE   = 'hF2;
  localparam int unsigned MEMGO_BIT    = 3;
  localparam int unsigned ERR_BASE     = 'hC1;

  typedef struct packed {
    logic               wr;
    logic [WORD_AW-1:0] word;
    logic [BE_W-1:0]    be;
    logic               memGoSet;
  } cfgStrb_t;

  function automatic logic [7:0] resetByte(int unsigned a);
    case (a)
      'h00: return 8'h57;  'h01: return 8'h10;
      'h02: return 8'h01;  'h04: return 8'h06;
      'h06: return 8'h80;  'h0B: return 8'h06;
      'hA8: return 8'h10;  'hAB: return 8'hFF;
      'hAC: return 8'h0C;  'hAD: return 8'h06;
      'hAE: return 8'h0C;  'hBA: return 8'h04;
      'hC0: return 8'h01;  'hF2: return 8'h02;
      'hF3: return 8'hFF;  'hF4: return 8'h03;
      'hFE: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wmaskByte(int unsigned a);
    if ((a >= 'h70 && a <= 'h71) || (a >= 'h80 && a <= 'hA0) ||
        (a >= 'hA8 && a <= 'hAF) || (a >= 'hBA && a <= 'hBB) ||
        a == 'hC0 || a == 'hC4)
      return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] w1cByte(int unsigned a);
    if (a == 'hC1 || a == 'hC3 || a == 'hC5 || a == 'hC7) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic int unsigned errSlot(int unsigned a);
    return (a - ERR_BASE) / 2;
  endfunction

  function automatic logic [SPACE_W-1:0] resetImage();
    logic [SPACE_W-1:0] img;
    for (int unsigned i = 0; i < CFG_BYTES; i++) img[8*i +: 8] = resetByte(i);
    return img;
  endfunction

endpackage

// File: rtl/hostcfg_ctrl.sv
module hostcfg_ctrl
  import hostcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [WORD_AW-1:0] cfgAddr,
  input  logic [BE_W-1:0]    cfgBe,
  input  logic               autoMemGo,
  output cfgStrb_t           strb,
  output logic               mapUpdate
);

  logic inMapWindow;
  logic mapHit;

  assign inMapWindow = (cfgAddr >= WORD_AW'(MAP_LO_WORD) && cfgAddr <= WORD_AW'(MAP_HI_WORD)) ||
                       (cfgAddr == WORD_AW'(MEMCFG_WORD));
  assign mapHit      = cfgWr && (|cfgBe) && inMapWindow;

  assign strb.wr       = cfgWr;
  assign strb.word     = cfgAddr;
  assign strb.be       = cfgBe;
  assign strb.memGoSet = autoMemGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mapUpdate <= 1'b0;
    else       mapUpdate <= mapHit;
  end

endmodule

// File: rtl/hostcfg_data.sv
module hostcfg_data
  import hostcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrb_t                  strb,
  input  logic [DATA_W-1:0]         cfgWdata,
  input  logic [WORD_AW-1:0]        cfgAddr,
  input  logic [8*ERR_BYTES-1:0]    errSet,
  output logic [DATA_W-1:0]         cfgRdata,
  output logic [8*NUM_BANKS-1:0]    bankStart,
  output logic [8*NUM_BANKS-1:0]    bankStartExt,
  output logic [8*NUM_BANKS-1:0]    bankEnd,
  output logic [8*NUM_BANKS-1:0]    bankEndExt,
  output logic [NUM_BANKS-1:0]      bankEn,
  output logic [63:0]               procCfg,
  output logic [31:0]               memCfg1
);

  localparam logic [SPACE_W-1:0] RESET_IMG = resetImage();

  logic [SPACE_W-1:0] space;
  logic [SPACE_W-1:0] nextSpace;

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam logic [7:0] WM = wmaskByte(i);
    localparam logic [7:0] CM = w1cByte(i);
    logic       hit;
    logic [7:0] cur, din, sets, nxt;

    assign cur = space[8*i +: 8];
    assign din = cfgWdata[8*(i%BE_W) +: 8];
    assign hit = strb.wr && (strb.word == WORD_AW'(i/BE_W)) && strb.be[i%BE_W];

    if (CM != 8'h00) begin : g_err
      assign sets = errSet[8*errSlot(i) +: 8];
    end else begin : g_noerr
      assign sets = 8'h00;
    end

    always_comb begin
      nxt = cur;
      if (hit) nxt = ((cur & ~WM) | (din & WM)) & ~(din & CM);
      nxt = nxt | (sets & CM);
      if (i == MEMGO_BYTE && strb.memGoSet) nxt[MEMGO_BIT] = 1'b1;
    end

    assign nextSpace[8*i +: 8] = nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) space <= RESET_IMG;
    else       space <= nextSpace;
  end

  assign cfgRdata     = space[DATA_W*cfgAddr +: DATA_W];
  assign bankStart    = space[8*'h80 +: 8*NUM_BANKS];
  assign bankStartExt = space[8*'h88 +: 8*NUM_BANKS];
  assign bankEnd      = space[8*'h90 +: 8*NUM_BANKS];
  assign bankEndExt   = space[8*'h98 +: 8*NUM_BANKS];
  assign bankEn       = space[8*'hA0 +: NUM_BANKS];
  assign procCfg      = space[8*'hA8 +: 64];
  assign memCfg1      = space[8*'hF0 +: 32];

endmodule

// File: rtl/hostcfg_space.sv
module hostcfg_space
  import hostcfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWr,
  input  logic [WORD_AW-1:0]     cfgAddr,
  input  logic [BE_W-1:0]        cfgBe,
  input  logic [DATA_W-1:0]      cfgWdata,
  output logic [DATA_W-1:0]      cfgRdata,
  input  logic [8*ERR_BYTES-1:0] errSet,
  input  logic                   autoMemGo,
  output logic [8*NUM_BANKS-1:0] bankStart,
  output logic [8*NUM_BANKS-1:0] bankStartExt,
  output logic [8*NUM_BANKS-1:0] bankEnd,
  output logic [8*NUM_BANKS-1:0] bankEndExt,
  output logic [NUM_BANKS-1:0]   bankEn,
  output logic [63:0]            procCfg,
  output logic [31:0]            memCfg1,
  output logic                   mapUpdate
);

  cfgStrb_t strb;

  hostcfg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgAddr   (cfgAddr),
    .cfgBe     (cfgBe),
    .autoMemGo (autoMemGo),
    .strb      (strb),
    .mapUpdate (mapUpdate)
  );

  hostcfg_data u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgWdata     (cfgWdata),
    .cfgAddr      (cfgAddr),
    .errSet       (errSet),
    .cfgRdata     (cfgRdata),
    .bankStart    (bankStart),
    .bankStartExt (bankStartExt),
    .bankEnd      (bankEnd),
    .bankEndExt   (bankEndExt),
    .bankEn       (bankEn),
    .procCfg      (procCfg),
    .memCfg1      (memCfg1)
  );

endmodule

// File: rtl/hostcfg_chk.sv
module hostcfg_chk
  import hostcfg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgWr,
  input logic [WORD_AW-1:0] cfgAddr,
  input logic [BE_W-1:0]    cfgBe,
  input logic               autoMemGo,
  input logic [DATA_W-1:0]  cfgRdata,
  input logic [NUM_BANKS-1:0] bankEn,
  input logic [31:0]        memCfg1,
  input logic               mapUpdate
);

  // R1: identity word never changes
  a_r1_identity: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == '0) |-> (cfgRdata == 32'h00011057));

  // R7: strobe only follows a write
  a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    mapUpdate |-> $past(cfgWr));

  // R7: write into window raises strobe next cycle
  a_r7_strobe_fires: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && (|cfgBe) && cfgAddr == WORD_AW'(MAP_HI_WORD)) |=> mapUpdate);

  // R4: word 0xF0 moves only through auto-configuration
  a_r4_memcfg_ro: assert property (@(posedge clk) disable iff (!rstN)
    !autoMemGo |=> $stable(memCfg1));

  // R8: auto-configuration sets the memory-enable bit
  a_r8_memgo: assert property (@(posedge clk) disable iff (!rstN)
    autoMemGo |=> memCfg1[19]);

  // R9: bank enables move only on a lane-0 write to their word
  a_r9_bank_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWr && cfgBe[0] && cfgAddr == WORD_AW'(MAP_HI_WORD)) |=> $stable(bankEn));

endmodule

bind hostcfg_space hostcfg_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWr     (cfgWr),
  .cfgAddr   (cfgAddr),
  .cfgBe     (cfgBe),
  .autoMemGo (autoMemGo),
  .cfgRdata  (cfgRdata),
  .bankEn    (bankEn),
  .memCfg1   (memCfg1),
  .mapUpdate (mapUpdate)
);

// File: tb/sim_hostcfg_space.sv
module sim_hostcfg_space;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [3:0]  cfgBe = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [31:0] errSet = '0;
  logic        autoMemGo = 1'b0;
  logic [63:0] bankStart, bankStartExt, bankEnd, bankEndExt, procCfg;
  logic [7:0]  bankEn;
  logic [31:0] memCfg1;
  logic        mapUpdate;

  int nChk = 0;
  int nFail = 0;
  logic updSeen;
  logic [31:0] rd;

  always #5 clk = ~clk;

  hostcfg_space u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .errSet(errSet), .autoMemGo(autoMemGo),
    .bankStart(bankStart), .bankStartExt(bankStartExt), .bankEnd(bankEnd),
    .bankEndExt(bankEndExt), .bankEn(bankEn), .procCfg(procCfg), .memCfg1(memCfg1),
    .mapUpdate(mapUpdate)
  );

  // {byteAddr, be, wdata, expected read, expected mapUpdate}; applied in order
  localparam int NV = 12;
  localparam logic [76:0] VEC [NV] = '{
    {8'h80, 4'hF, 32'h11223344, 32'h11223344, 1'b1},  // R3 R7
    {8'h80, 4'h5, 32'hAABBCCDD, 32'h11BB33DD, 1'b1},  // R3 lanes
    {8'hA0, 4'hF, 32'hFFFFFFFF, 32'h000000FF, 1'b1},  // R3 R4 R7 window top
    {8'hA8, 4'hF, 32'h12345678, 32'h12345678, 1'b0},  // R3
    {8'h40, 4'hF, 32'hFFFFFFFF, 32'h00000000, 1'b0},  // R4
    {8'hF0, 4'hF, 32'hFFFFFFFF, 32'hFF020000, 1'b1},  // R4 R7
    {8'h70, 4'hF, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0},  // R3 R4
    {8'hB8, 4'hF, 32'hFFFFFFFF, 32'hFFFF0000, 1'b0},  // R3 R4
    {8'h00, 4'hF, 32'h00000000, 32'h00011057, 1'b0},  // R4 header
    {8'h9C, 4'h0, 32'hFFFFFFFF, 32'h00000000, 1'b0},  // R3 R7 no lanes
    {8'hC4, 4'hF, 32'hFFFFFFFF, 32'h000000FF, 1'b0},  // R10
    {8'hA4, 4'hF, 32'hFFFFFFFF, 32'h00000000, 1'b0}   // R4 R7 past window
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = a[7:2]; cfgBe = be; cfgWdata = d;
    @(negedge clk);
    cfgWr = 1'b0; cfgBe = '0;
    updSeen = mapUpdate;
  endtask

  task automatic rdw(logic [7:0] a, output logic [31:0] v);
    cfgAddr = a[7:2];
    #1;
    v = cfgRdata;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R7 reset strobe", mapUpdate, 0);
    rdw(8'h00, rd); check("R1 id", rd, 32'h00011057);
    rdw(8'h04, rd); check("R1 cmd/status", rd, 32'h00800006);
    rdw(8'h08, rd); check("R1 class", rd, 32'h06000000);
    rdw(8'hA8, rd); check("R2 A8", rd, 32'hFF000010);
    rdw(8'hAC, rd); check("R2 AC", rd, 32'h000C060C);
    rdw(8'hB8, rd); check("R2 B8", rd, 32'h00040000);
    rdw(8'hC0, rd); check("R2 C0", rd, 32'h00000001);
    rdw(8'hF0, rd); check("R2 F0", rd, 32'hFF020000);
    rdw(8'hF4, rd); check("R2 F4", rd, 32'h00000003);
    rdw(8'hFC, rd); check("R2 FC", rd, 32'h00100000);
    rdw(8'h80, rd); check("R2 80", rd, 32'h00000000);

    // table walk
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][76:69], VEC[k][68:65], VEC[k][64:33]);
      check("R7 strobe", updSeen, VEC[k][0]);
      rdw(VEC[k][76:69], rd);
      check("R3/R4 readback", rd, VEC[k][32:1]);
    end
    @(negedge clk);
    check("R7 one cycle", mapUpdate, 0);

    // R9 exports
    check("R9 bankStart", bankStart[31:0], 32'h11BB33DD);
    check("R9 bankEn", bankEn, 8'hFF);
    check("R9 procCfg", procCfg, 64'h000C060C_12345678);
    check("R9 bankEnd", bankEnd, 64'h0);

    // R6 set via errSet
    @(negedge clk); errSet = 32'h810000F0;
    @(negedge clk); errSet = '0;
    rdw(8'hC0, rd); check("R6 set C1", rd, 32'h0000F001);
    rdw(8'hC4, rd); check("R6 set C7", rd, 32'h810000FF);

    // R5 clear on write
    wr(8'hC0, 4'h2, 32'h00003000);
    rdw(8'hC0, rd); check("R5 w1c", rd, 32'h0000C001);
    wr(8'hC0, 4'h2, 32'h00000000);
    rdw(8'hC0, rd); check("R5 zero keeps", rd, 32'h0000C001);

    // R6 set beats clear on bit 6, bit 7 cleared
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = 6'h30; cfgBe = 4'h2; cfgWdata = 32'h0000C000; errSet = 32'h00000040;
    @(negedge clk);
    cfgWr = 1'b0; cfgBe = '0; errSet = '0;
    rdw(8'hC0, rd); check("R6 set wins", rd, 32'h00004001);

    // R10 mixed word
    wr(8'hC0, 4'hF, 32'hFFFFFFFF);
    rdw(8'hC0, rd); check("R10 mixed", rd, 32'h000000FF);
    wr(8'hC4, 4'hF, 32'hFFFFFFFF);
    rdw(8'hC4, rd); check("R10 mixed C4", rd, 32'h000000FF);

    // R8 auto-configuration
    @(negedge clk); autoMemGo = 1'b1;
    @(negedge clk); autoMemGo = 1'b0;
    check("R8 memCfg1", memCfg1, 32'hFF0A0000);
    check("R8 no strobe", mapUpdate, 0);
    rdw(8'hF0, rd); check("R8 readback", rd, 32'hFF0A0000);

    summary();
  end

endmodule